// File: doc/BRIEF.md
# Dual-Width Condition Code Unit

This unit sits beside the integer adder of a 64-bit datapath that must also run 32-bit code. It takes the two operands and the add/subtract control of an arithmetic operation. From that one operation it derives two independent flag sets in the same cycle. The narrow set describes the low 32 bits of the result. The wide set describes the full 64-bit result. Each set holds sign (N), zero (Z), signed overflow (V) and carry (C).

Both sets are written together on a clock edge when the update enable is high, and they hold their value otherwise. A branch picks one of the two sets and one of sixteen condition codes. The taken bit is formed combinationally from the stored flags of the chosen set, so it reflects an update in the cycle right after the enabling edge.

The unit has no sequencing of its own. Its only state is the two flag registers: reset, then loaded or held on each clock.

Top module: `ccpu_top`

## Requirements
- R1: While reset (rst_n low) is applied, all eight flags are cleared. Both sets then give EQ=0, NE=1, MI=0, PL=1, VS=0, VC=1, CS=0, CC=1, HI=0, LS=1, GE=1, LT=0, GT=1, LE=0, AL=1, NV=0.
- R2: The narrow set is taken from bits 31:0 of the result. N is bit 31, Z is set when bits 31:0 are all zero, and C is the carry out of bit 31.
- R3: The wide set is taken from the whole 64-bit result. N is bit 63, Z is set when all 64 bits are zero, and C is the carry out of bit 63.
- R4: With op_sub=1 the result is opnd_a minus opnd_b. C=1 means no borrow, so C is set exactly when the minuend is not below the subtrahend (unsigned, at that set's width). With op_sub=0 the result is opnd_a plus opnd_b.
- R5: V is set when the result, read as two's complement at that set's width, is not the true signed sum or difference.
- R6: When upd_en is low, neither set changes, whatever the operands and op_sub.
- R7: set_sel=0 makes the branch read the narrow set. set_sel=1 makes it read the wide set.
- R8: cond_sel codes 0 EQ (Z), 1 NE (!Z), 2 MI (N) and 3 PL (!N) test zero and sign.
- R9: cond_sel codes 4 VS (V), 5 VC (!V), 6 CS (C) and 7 CC (!C) test overflow and carry.
- R10: cond_sel codes 8 HI (C&!Z), 9 LS (!C|Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z&N==V), 13 LE (Z|N!=V), 14 AL (1) and 15 NV (0) give the compound tests.
- R11: br_taken depends only on the stored flags, set_sel and cond_sel. It reflects an update from the first clock edge after that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 64 | First operand (minuend for subtract) |
| opnd_b | input | 64 | Second operand (subtrahend for subtract) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| upd_en | input | 1 | Write both flag sets at the next edge |
| cond_sel | input | 4 | Branch condition code |
| set_sel | input | 1 | 0 = narrow 32-bit set, 1 = wide 64-bit set |
| br_taken | output | 1 | Branch condition result |

## Verification
A wrong stored flag in either set appears at br_taken in the cycle right after the edge that wrote it. It is only visible through the conditions that read that flag and only when the matching set is selected. For that reason, every directed update is followed by a sweep of all sixteen codes on both sets before the next operation. Differences between the widths, such as a 32-bit wrap that leaves the 64-bit result non-zero, show up only when the same code is compared across set_sel. A lost hold shows up the cycle after a disabled write with different operands.

// File: rtl/ccpu_pkg.sv
package ccpu_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccflags_t;

    typedef enum logic [3:0] {
        CND_EQ = 4'd0,
        CND_NE = 4'd1,
        CND_MI = 4'd2,
        CND_PL = 4'd3,
        CND_VS = 4'd4,
        CND_VC = 4'd5,
        CND_CS = 4'd6,
        CND_CC = 4'd7,
        CND_HI = 4'd8,
        CND_LS = 4'd9,
        CND_GE = 4'd10,
        CND_LT = 4'd11,
        CND_GT = 4'd12,
        CND_LE = 4'd13,
        CND_AL = 4'd14,
        CND_NV = 4'd15
    } cond_e;

    localparam int NUM_SETS = 2;

endpackage

// File: rtl/ccpu_flaggen.sv
module ccpu_flaggen
    import ccpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output ccflags_t     f
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum;

    // subtract as a + ~b + 1, so the carry out reads as "no borrow"
    assign b_eff = sub ? ~b : b;
    assign sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

    always_comb begin
        f.n = sum[W-1];
        f.z = (sum[W-1:0] == '0);
        f.c = sum[W];
        f.v = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/ccpu_flagreg.sv
module ccpu_flagreg
    import ccpu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  ccflags_t d,
    output ccflags_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/ccpu_condeval.sv
module ccpu_condeval
    import ccpu_pkg::*;
(
    input  ccflags_t    f,
    input  logic [3:0]  code,
    output logic        taken
);
    cond_e cnd;
    assign cnd = cond_e'(code);

    always_comb begin
        unique case (cnd)
            CND_EQ: taken = f.z;
            CND_NE: taken = !f.z;
            CND_MI: taken = f.n;
            CND_PL: taken = !f.n;
            CND_VS: taken = f.v;
            CND_VC: taken = !f.v;
            CND_CS: taken = f.c;
            CND_CC: taken = !f.c;
            CND_HI: taken = f.c && !f.z;
            CND_LS: taken = !f.c || f.z;
            CND_GE: taken = (f.n == f.v);
            CND_LT: taken = (f.n != f.v);
            CND_GT: taken = !f.z && (f.n == f.v);
            CND_LE: taken = f.z || (f.n != f.v);
            CND_AL: taken = 1'b1;
            CND_NV: taken = 1'b0;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/ccpu_top.sv
module ccpu_top
    import ccpu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LOW_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              op_sub,
    input  logic              upd_en,
    input  logic [3:0]        cond_sel,
    input  logic              set_sel,
    output logic              br_taken
);
    ccflags_t nxt [NUM_SETS];
    ccflags_t cur [NUM_SETS];
    ccflags_t lo_q;
    ccflags_t hi_q;
    ccflags_t sel_f;

    // set 0 = low slice, set 1 = full width
    for (genvar gi = 0; gi < NUM_SETS; gi++) begin : g_set
        localparam int SW = (gi == 0) ? LOW_W : DATA_W;
        ccpu_flaggen #(.W(SW)) gen_i (
            .a   (opnd_a[SW-1:0]),
            .b   (opnd_b[SW-1:0]),
            .sub (op_sub),
            .f   (nxt[gi])
        );
        ccpu_flagreg reg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (upd_en),
            .d     (nxt[gi]),
            .q     (cur[gi])
        );
    end

    assign lo_q  = cur[0];
    assign hi_q  = cur[1];
    assign sel_f = set_sel ? hi_q : lo_q;

    ccpu_condeval eval_i (
        .f     (sel_f),
        .code  (cond_sel),
        .taken (br_taken)
    );
endmodule

// File: rtl/ccpu_chk.sv
module ccpu_chk
    import ccpu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] opnd_a,
    input logic [63:0] opnd_b,
    input logic        op_sub,
    input logic        upd_en,
    input logic [3:0]  cond_sel,
    input logic        set_sel,
    input logic        br_taken,
    input ccflags_t    lo_q,
    input ccflags_t    hi_q
);
    // R6
    hold_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(lo_q));
    // R6
    hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(hi_q));
    // R2
    zero_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !op_sub && opnd_a == 64'd0 && opnd_b == 64'd0)
        |=> (lo_q.z && hi_q.z && !lo_q.c && !hi_q.c && !lo_q.v));
    // R4
    equal_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sub && opnd_a == opnd_b)
        |=> (lo_q.z && hi_q.z && lo_q.c && hi_q.c && !hi_q.n));
    // R10
    always_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd14) |-> br_taken);
    // R10
    never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd15) |-> !br_taken);
    // R7
    wide_zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd0 && set_sel) |-> (br_taken == hi_q.z));
    // R7
    narrow_zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd0 && !set_sel) |-> (br_taken == lo_q.z));
endmodule

bind ccpu_top ccpu_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .op_sub   (op_sub),
    .upd_en   (upd_en),
    .cond_sel (cond_sel),
    .set_sel  (set_sel),
    .br_taken (br_taken),
    .lo_q     (lo_q),
    .hi_q     (hi_q)
);

// File: tb/ccpu_top_tb_top.sv
module ccpu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        op_sub = 1'b0;
    logic        upd_en = 1'b0;
    logic [3:0]  cond_sel = '0;
    logic        set_sel = 1'b0;
    logic        br_taken;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // reference flags as {n,z,v,c}
    logic [3:0] ref_lo = 4'b0;
    logic [3:0] ref_hi = 4'b0;

    always #4 clk = ~clk;

    ccpu_top dut_i (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sub(op_sub), .upd_en(upd_en), .cond_sel(cond_sel),
        .set_sel(set_sel), .br_taken(br_taken)
    );

    // flags from arithmetic at width w (32 or 64), written from the requirements
    function automatic logic [3:0] model_flags(input logic [63:0] a, input logic [63:0] b,
                                               input logic sub, input int w);
        logic [63:0] mask, am, bm, r;
        logic n, z, v, c, sa, sb, sr;
        mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        am = a & mask;
        bm = b & mask;
        r  = (sub ? (am - bm) : (am + bm)) & mask;
        sa = am[w-1];
        sb = bm[w-1];
        sr = r[w-1];
        n = sr;
        z = (r == 64'd0);
        if (sub) begin
            c = (am >= bm);
            v = (sa != sb) && (sr != sa);
        end else begin
            c = (r < am);
            v = (sa == sb) && (sr != sa);
        end
        return {n, z, v, c};
    endfunction

    function automatic logic model_taken(input logic [3:0] f, input int code);
        logic n, z, v, c;
        {n, z, v, c} = f;
        case (code)
            0: return z;
            1: return !z;
            2: return n;
            3: return !n;
            4: return v;
            5: return !v;
            6: return c;
            7: return !c;
            8: return c && !z;
            9: return !c || z;
            10: return n == v;
            11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string code_tag(input int code);
        if (code < 4) return "R8";
        if (code < 8) return "R9";
        return "R10";
    endfunction

    task automatic compare(input string tag);
        logic exp;
        exp = model_taken(set_sel ? ref_hi : ref_lo, int'(cond_sel));
        n_vec++;
        if (br_taken !== exp) begin
            n_bad++;
            $display("FAIL %s/%s sel=%0d code=%0d got=%b exp=%b", tag, code_tag(int'(cond_sel)),
                     set_sel, cond_sel, br_taken, exp);
        end
    endtask

    // at a low clock phase: try every code on both sets
    task automatic sweep(input string tag);
        upd_en = 1'b0;
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 16; k++) begin
                set_sel  = s[0];
                cond_sel = k[3:0];
                #0.2;
                compare(tag);
            end
        end
    endtask

    // drive one update at the falling edge, commit the model at the rising edge
    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic sub, input logic upd);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sub = sub; upd_en = upd;
        @(posedge clk);
        if (upd) begin
            ref_lo = model_flags(a, b, sub, 32);
            ref_hi = model_flags(a, b, sub, 64);
        end
        @(negedge clk);
        upd_en = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        sweep("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3: narrow wraps to zero with carry, wide does not
        apply(64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 1'b1);
        sweep("R2_R3_R11");
        // R5: narrow signed overflow only
        apply(64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0, 1'b1);
        sweep("R5");
        // R5: wide signed overflow, narrow carry-to-zero
        apply(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b1);
        sweep("R5");
        // R6: disabled update with unrelated operands
        apply(64'd0, 64'd0, 1'b1, 1'b0);
        sweep("R6");
        // R4: equal subtract
        apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b1);
        sweep("R4");
        // R4: borrow
        apply(64'd3, 64'd5, 1'b1, 1'b1);
        sweep("R4");
        // R5: narrow subtract overflow
        apply(64'h0000_0000_8000_0000, 64'd1, 1'b1, 1'b1);
        sweep("R5_R7");
        // R3: wide carry out of bit 63
        apply(64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 1'b0, 1'b1);
        sweep("R3");

        // random traffic, compared every cycle
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ra, rb;
            logic rs, ru;
            @(negedge clk);
            ra = {$urandom, $urandom};
            rb = (i % 7 == 0) ? ra : {$urandom, $urandom};
            rs = $urandom % 2;
            ru = ($urandom % 3) != 0;
            opnd_a = ra; opnd_b = rb; op_sub = rs; upd_en = ru;
            set_sel = $urandom % 2;
            cond_sel = 4'($urandom % 16);
            #1;
            compare("R11");
            @(posedge clk);
            if (ru) begin
                ref_lo = model_flags(ra, rb, rs, 32);
                ref_hi = model_flags(ra, rb, rs, 64);
            end
        end
        @(negedge clk);
        #1;
        sweep("R7");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule